// File: doc/BRIEF.md
# Pin-Selected Power Mode Controller

The block turns two externally driven mode-select pins into one of four power states: normal, reduced, low power and sleep. It resynchronises the pins, filters short glitches and then carries out the side effects of each accepted change. It keeps a small register file behind a simple parallel read/write port, which stands in for the serial host interface. That port is gated by the current state: full access in normal mode, only the three per-phase mean-absolute-value results in reduced mode, and nothing in low-power or sleep mode.

Entering normal mode runs a fixed-length transition. During it every control register goes back to its default, except the low-power threshold register and one configuration register, which keep what they held. At the end of the transition a reset-done flag is raised together with an active-low interrupt that no mask bit can suppress. Reduced mode raises the same interrupt line at the start of its computation only when it is entered from low-power or sleep mode. When it is entered from normal mode it starts silently.

Top module: `pwrmode_top`

## Requirements
- R1: The state is decoded from {modeSelHi, modeSelLo} as 00 = reduced, 01 = normal, 10 = low power, 11 = sleep, and the accepted state is shown on powerMode with that same code. After reset powerMode is 11 (sleep), irqN is 1 and busy is 0.
- R2: The pins pass through two synchronising flops. A new code is accepted only when the synchronised value is equal in two consecutive clocks and differs from the current state, so a pin pulse one clock long leaves the state unchanged.
- R3: On entry to normal mode, the mask register (address 1, default 0) and the control register (address 4, default 0xA5) return to their defaults. The threshold register (address 2, 8 bits, reset value 0x07) and the configuration register (address 3, reset value 0) keep their contents.
- R4: After normal mode is entered, busy is 1 for exactly TRANS_CYC clocks (default 16), and writes made while busy is 1 are ignored.
- R5: Bit 15 of the status register (address 0) is the reset-done flag. It reads 0 during the transition and reads 1 once busy falls, and irqN goes low at the same moment.
- R6: Writing a 1 to status bit 15 clears the flag and drives irqN high again. Writing 0 to bit 15 leaves both unchanged.
- R7: The value of mask register bit 15 has no effect on the reset-done interrupt.
- R8: In reduced mode, reads of addresses 5, 6 and 7 return the phase A, B and C mean-absolute-value inputs, zero-extended. Reads of addresses 0 to 4 return 0, and all writes are ignored.
- R9: Entry to reduced mode from normal mode leaves irqN high. Entry from low-power or sleep mode drives irqN low and sets status bit 14.
- R10: In low-power and sleep modes every read returns 0 and every write is ignored.
- R11: Every accepted state change clears both status flags, so irqN is high after the change unless R5 or R9 sets a flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| modeSelHi | input | 1 | Upper mode-select pin (asynchronous) |
| modeSelLo | input | 1 | Lower mode-select pin (asynchronous) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Combinational read data, gated by mode |
| mavA | input | MAV_W | Phase A mean-absolute-value result |
| mavB | input | MAV_W | Phase B mean-absolute-value result |
| mavC | input | MAV_W | Phase C mean-absolute-value result |
| powerMode | output | 2 | Accepted power state code |
| busy | output | 1 | Normal-mode transition in progress |
| irqN | output | 1 | Active-low interrupt |

## Verification
The assertions assume that the mode pins, once moved, hold their new value long enough for the filter to see it. They also assume that the host does not write during the clock in which a state change is accepted. The bench changes pins only on falling edges and then waits several tens of clocks before it looks at the result; the exception is the deliberate one-clock glitch used for R2. Host writes are issued only after the state has settled, except the single write placed inside the busy window to test R4. The sweep walks all twelve ordered pairs of distinct states and checks the state code, the interrupt line and the gated reads after each change.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;
  typedef enum logic [1:0] {
    MODE_REDUCED = 2'b00,
    MODE_NORMAL  = 2'b01,
    MODE_LOW     = 2'b10,
    MODE_SLEEP   = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    RD_ALL  = 2'd0,
    RD_MAV  = 2'd1,
    RD_NONE = 2'd2
  } rd_scope_e;

  typedef struct packed {
    logic      wrAllow;
    logic      softReset;
    logic      clearFlags;
    logic      setDone;
    logic      setStart;
    rd_scope_e rdScope;
  } ctl_strobe_t;

  localparam int ADR_STATUS = 0;
  localparam int ADR_MASK   = 1;
  localparam int ADR_LPTHR  = 2;
  localparam int ADR_CFG    = 3;
  localparam int ADR_CTRL   = 4;
  localparam int ADR_MAV_A  = 5;
  localparam int ADR_MAV_B  = 6;
  localparam int ADR_MAV_C  = 7;

  localparam int DONE_BIT  = 15;
  localparam int START_BIT = 14;
endpackage

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int TRANS_CYC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        modeSelHi,
  input  logic        modeSelLo,
  output pwr_mode_e   curMode,
  output logic        busy,
  output ctl_strobe_t strb
);
  localparam int CNT_W = $clog2(TRANS_CYC + 1);

  logic [1:0] syncQ1, syncQ2, candReg;
  logic [CNT_W-1:0] busyCnt;
  pwr_mode_e newMode;
  logic accept;

  // two-flop synchroniser plus one-sample hold for the stability filter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ1  <= 2'b11;
      syncQ2  <= 2'b11;
      candReg <= 2'b11;
    end else begin
      syncQ1  <= {modeSelHi, modeSelLo};
      syncQ2  <= syncQ1;
      candReg <= syncQ2;
    end
  end

  assign newMode = pwr_mode_e'(syncQ2);
  assign accept  = (syncQ2 == candReg) && (newMode != curMode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curMode <= MODE_SLEEP;
      busyCnt <= '0;
    end else begin
      if (accept) begin
        curMode <= newMode;
        busyCnt <= (newMode == MODE_NORMAL) ? CNT_W'(TRANS_CYC) : '0;
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end

  assign busy = (busyCnt != '0);

  always_comb begin
    strb.clearFlags = accept;
    strb.softReset  = accept && (newMode == MODE_NORMAL);
    strb.setStart   = accept && (newMode == MODE_REDUCED) &&
                      ((curMode == MODE_LOW) || (curMode == MODE_SLEEP));
    strb.setDone    = !accept && (busyCnt == CNT_W'(1));
    strb.wrAllow    = (curMode == MODE_NORMAL) && !busy;
    case (curMode)
      MODE_NORMAL:  strb.rdScope = RD_ALL;
      MODE_REDUCED: strb.rdScope = RD_MAV;
      default:      strb.rdScope = RD_NONE;
    endcase
  end

  // R4: the transition window only exists in normal mode
  assert_busy_normal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> curMode == MODE_NORMAL);

  // R2: a state change always matches the filtered sample held the cycle before
  assert_filtered_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (curMode != $past(curMode)) |-> ($past(candReg) == curMode));

  // R4: entering normal starts a full-length transition
  assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.softReset |=> busy);
endmodule

// File: rtl/pwrmode_regs.sv
module pwrmode_regs
  import pwrmode_pkg::*;
#(
  parameter int          DATA_W    = 24,
  parameter int          ADDR_W    = 3,
  parameter int          MAV_W     = 20,
  parameter int          LPTHR_W   = 8,
  parameter logic [7:0]  LPTHR_DEF = 8'h07,
  parameter logic [23:0] CTRL_DEF  = 24'h0000A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_strobe_t       strb,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [MAV_W-1:0]  mavA,
  input  logic [MAV_W-1:0]  mavB,
  input  logic [MAV_W-1:0]  mavC,
  output logic              irqN
);
  localparam int PAD_W = DATA_W - MAV_W;

  logic [DATA_W-1:0]  maskReg, cfgReg, ctrlReg;
  logic [LPTHR_W-1:0] lpthrReg;
  logic doneFlag, startFlag;
  logic hitStatus, hitMask, hitLpthr, hitCfg, hitCtrl;

  assign hitStatus = strb.wrAllow && wrEn && (wrAddr == ADDR_W'(ADR_STATUS));
  assign hitMask   = strb.wrAllow && wrEn && (wrAddr == ADDR_W'(ADR_MASK));
  assign hitLpthr  = strb.wrAllow && wrEn && (wrAddr == ADDR_W'(ADR_LPTHR));
  assign hitCfg    = strb.wrAllow && wrEn && (wrAddr == ADDR_W'(ADR_CFG));
  assign hitCtrl   = strb.wrAllow && wrEn && (wrAddr == ADDR_W'(ADR_CTRL));

  // registers reset on normal-mode entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskReg <= '0;
      ctrlReg <= DATA_W'(CTRL_DEF);
    end else if (strb.softReset) begin
      maskReg <= '0;
      ctrlReg <= DATA_W'(CTRL_DEF);
    end else begin
      if (hitMask) maskReg <= wrData;
      if (hitCtrl) ctrlReg <= wrData;
    end
  end

  // registers retained across normal-mode entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpthrReg <= LPTHR_W'(LPTHR_DEF);
      cfgReg   <= '0;
    end else begin
      if (hitLpthr) lpthrReg <= wrData[LPTHR_W-1:0];
      if (hitCfg)   cfgReg   <= wrData;
    end
  end

  // status flags: clear on mode change, set by control, write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doneFlag  <= 1'b0;
      startFlag <= 1'b0;
    end else if (strb.clearFlags) begin
      doneFlag  <= 1'b0;
      startFlag <= strb.setStart;
    end else begin
      if (strb.setDone) doneFlag <= 1'b1;
      else if (hitStatus && wrData[DONE_BIT]) doneFlag <= 1'b0;
      if (hitStatus && wrData[START_BIT]) startFlag <= 1'b0;
    end
  end

  // mask register is deliberately not consulted: the interrupt is unmaskable
  assign irqN = !(doneFlag || startFlag);

  always_comb begin
    rdData = '0;
    if (strb.rdScope != RD_NONE) begin
      case (rdAddr)
        ADDR_W'(ADR_MAV_A): rdData = {{PAD_W{1'b0}}, mavA};
        ADDR_W'(ADR_MAV_B): rdData = {{PAD_W{1'b0}}, mavB};
        ADDR_W'(ADR_MAV_C): rdData = {{PAD_W{1'b0}}, mavC};
        default: begin
          if (strb.rdScope == RD_ALL) begin
            case (rdAddr)
              ADDR_W'(ADR_STATUS): begin
                rdData[DONE_BIT]  = doneFlag;
                rdData[START_BIT] = startFlag;
              end
              ADDR_W'(ADR_MASK):  rdData = maskReg;
              ADDR_W'(ADR_LPTHR): rdData = {{(DATA_W-LPTHR_W){1'b0}}, lpthrReg};
              ADDR_W'(ADR_CFG):   rdData = cfgReg;
              ADDR_W'(ADR_CTRL):  rdData = ctrlReg;
              default:            rdData = '0;
            endcase
          end
        end
      endcase
    end
  end

  // R3/R8/R10: retained threshold moves only by an accepted host write
  assert_lpthr_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hitLpthr |=> $stable(lpthrReg));

  // R8/R10: mask register changes only through a permitted write or normal entry
  assert_mask_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.wrAllow && !strb.softReset) |=> $stable(maskReg));

  // R7: completion raises the interrupt whatever the mask holds
  assert_done_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.setDone |=> !irqN);

  // R11: a state change without a start event leaves the line released
  assert_flags_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.clearFlags && !strb.setStart) |=> irqN);
endmodule

// File: rtl/pwrmode_top.sv
module pwrmode_top
  import pwrmode_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int ADDR_W    = 3,
  parameter int MAV_W     = 20,
  parameter int TRANS_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeSelHi,
  input  logic              modeSelLo,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [MAV_W-1:0]  mavA,
  input  logic [MAV_W-1:0]  mavB,
  input  logic [MAV_W-1:0]  mavC,
  output logic [1:0]        powerMode,
  output logic              busy,
  output logic              irqN
);
  pwr_mode_e   curMode;
  ctl_strobe_t strb;

  pwrmode_ctrl #(.TRANS_CYC(TRANS_CYC)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .modeSelHi(modeSelHi), .modeSelLo(modeSelLo),
    .curMode(curMode), .busy(busy), .strb(strb)
  );

  pwrmode_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAV_W(MAV_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .mavA(mavA),
    .mavB(mavB), .mavC(mavC), .irqN(irqN)
  );

  assign powerMode = curMode;

  // R5: a completed transition leaves the interrupt asserted
  assert_done_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && powerMode == 2'b01) |-> !irqN);

  // R10: low-power and sleep expose nothing on the read port
  assert_quiet_reads_R10: assert property (@(posedge clk) disable iff (!rst_n)
    powerMode[1] |-> rdData == '0);
endmodule

// File: tb/test_pwrmode_top.sv
module test_pwrmode_top;
  localparam int DW = 24;
  localparam int AW = 3;
  localparam int MW = 20;
  localparam int TC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic modeSelHi = 1'b1, modeSelLo = 1'b1;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0;
  logic [DW-1:0] wrData = '0, rdData;
  logic [MW-1:0] mavA = 20'hABCDE, mavB = 20'h13579, mavC = 20'hF0F0F;
  logic [1:0] powerMode;
  logic busy, irqN;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwrmode_top #(.DATA_W(DW), .ADDR_W(AW), .MAV_W(MW), .TRANS_CYC(TC)) i_pwrmode_top (
    .clk(clk), .rst_n(rst_n), .modeSelHi(modeSelHi), .modeSelLo(modeSelLo),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .mavA(mavA), .mavB(mavB), .mavC(mavC),
    .powerMode(powerMode), .busy(busy), .irqN(irqN)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setPins(input int m);
    @(negedge clk);
    modeSelHi = m[1];
    modeSelLo = m[0];
  endtask

  task automatic goMode(input int m);
    setPins(m);
    repeat (TC + 20) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    rdAddr = AW'(a);
    #1;
    v = rdData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset mode", 32'(powerMode), 32'h3);
    check("R1 reset irq", 32'(irqN), 32'h1);
    check("R1 reset busy", 32'(busy), 32'h0);
    rd(5, v); check("R10 sleep read", 32'(v), 32'h0);

    // R4/R5: enter normal, measure transition
    setPins(1);
    n = 0;
    while (!busy && n < 20) begin @(negedge clk); n++; end
    rd(0, v); check("R5 done bit during transition", 32'(v[15]), 32'h0);
    n = 0;
    while (busy && n < 100) begin @(negedge clk); n++; end
    check("R4 busy length", 32'(n), 32'(TC));
    check("R5 irq after transition", 32'(irqN), 32'h0);
    rd(0, v); check("R5 status after transition", 32'(v), 32'h8000);
    check("R1 normal code", 32'(powerMode), 32'h1);

    // R7: mask bit 15 has no effect
    wr(1, 24'h008000); check("R7 mask bit set irq", 32'(irqN), 32'h0);
    wr(1, 24'h000000); check("R7 mask bit clear irq", 32'(irqN), 32'h0);

    // R6: write-one-to-clear
    wr(0, 24'h004000); check("R6 zero in bit15 keeps irq", 32'(irqN), 32'h0);
    rd(0, v); check("R6 flag kept", 32'(v[15]), 32'h1);
    wr(0, 24'h008000); check("R6 clear irq", 32'(irqN), 32'h1);
    rd(0, v); check("R6 flag cleared", 32'(v[15]), 32'h0);

    // configure registers
    wr(2, 24'h00005A); wr(3, 24'h123456); wr(4, 24'h00BEEF); wr(1, 24'h0000F0);
    rd(2, v); check("R3 lpthr write", 32'(v), 32'h5A);
    rd(3, v); check("R3 cfg write", 32'(v), 32'h123456);
    rd(4, v); check("R3 ctrl write", 32'(v), 32'hBEEF);
    rd(1, v); check("R3 mask write", 32'(v), 32'hF0);

    // R8/R9: reduced from normal
    goMode(0);
    check("R9 from normal no irq", 32'(irqN), 32'h1);
    check("R1 reduced code", 32'(powerMode), 32'h0);
    rd(5, v); check("R8 mav A", 32'(v), 32'hABCDE);
    rd(6, v); check("R8 mav B", 32'(v), 32'h13579);
    rd(7, v); check("R8 mav C", 32'(v), 32'hF0F0F);
    for (int a = 0; a < 5; a++) begin
      rd(a, v); check($sformatf("R8 gated read addr %0d", a), 32'(v), 32'h0);
    end
    wr(2, 24'h000011);
    wr(0, 24'h000000);

    // R2: one-clock glitch toward normal is rejected
    setPins(1); setPins(0);
    repeat (10) @(negedge clk);
    check("R2 glitch mode", 32'(powerMode), 32'h0);
    check("R2 glitch busy", 32'(busy), 32'h0);

    // R3/R4: back to normal, write during busy is dropped
    setPins(1);
    n = 0;
    while (!busy && n < 20) begin @(negedge clk); n++; end
    wrEn = 1'b1; wrAddr = AW'(4); wrData = 24'h000777;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (TC + 10) @(negedge clk);
    rd(4, v); check("R3 R4 ctrl default after entry", 32'(v), 32'hA5);
    rd(1, v); check("R3 mask default after entry", 32'(v), 32'h0);
    rd(2, v); check("R3 R8 lpthr retained", 32'(v), 32'h5A);
    rd(3, v); check("R3 cfg retained", 32'(v), 32'h123456);

    // R10: writes ignored in low-power mode
    goMode(2);
    wr(3, 24'h000BAD);
    goMode(1);
    rd(3, v); check("R10 low write ignored", 32'(v), 32'h123456);

    // exhaustive sweep over ordered pairs of states
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        if (f != t) begin
          logic expIrq;
          logic [DW-1:0] expStat, expMav;
          goMode(f);
          goMode(t);
          expIrq  = !((t == 1) || (t == 0 && f >= 2));
          expStat = (t == 1) ? 24'h008000 : 24'h0;
          expMav  = (t <= 1) ? 24'h0ABCDE : 24'h0;
          check($sformatf("R1 sweep %0d->%0d mode", f, t), 32'(powerMode), 32'(t));
          check($sformatf("R9 R11 sweep %0d->%0d irq", f, t), 32'(irqN), 32'(expIrq));
          rd(0, v);
          check($sformatf("R5 R10 sweep %0d->%0d status", f, t), 32'(v), 32'(expStat));
          rd(5, v);
          check($sformatf("R8 R10 sweep %0d->%0d mav", f, t), 32'(v), 32'(expMav));
        end
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule